// File: doc/BRIEF.md
# Paged Write Collector with Lower-Quarter Lock

This block sits between the serial slave engine of a byte-wide nonvolatile store and its storage array. Once the slave engine has decoded a write selection and the two address bytes, it hands the block the starting address. Each data byte that follows is placed in a 32-byte page buffer at the current in-page offset. Only the five low offset bits advance, so a page that is overrun wraps onto its own first bytes. The block tells the engine, byte by byte, whether the byte may be acknowledged.

When the engine reports a STOP that closes a write holding at least one accepted byte, the block starts one self-timed program cycle. The cycle lasts a parameter number of clock cycles. Busy is raised for all of it, so the engine ignores the bus. In the final busy cycle the block issues a single page-wide array write that carries the page number, the buffered bytes and a mask of the bytes actually received. A one-byte write and a full page write take exactly the same path.

A write-protect input locks the lowest quarter of the address space. A session aimed there while protect is high refuses its data byte, stays refused, and programs nothing.

Top module: `pgwr_buffer`

## Requirements
- R1: After reset, ack_ok_o, busy_o and arr_we_o are all low.
- R2: wsel_i loads wsel_addr_i. The page number is bits [12:5] and the in-page offset is bits [4:0]. Each accepted byte is stored at the current offset, and then the offset increments while the page number stays unchanged.
- R3: The offset counts modulo 32. Bytes 33 and later overwrite the earlier bytes at the same offsets, and the last value written at an offset is the one committed.
- R4: arr_mask_o bit k is 1 exactly when a byte was accepted at offset k during the session. arr_data_o bits [8k+7:8k] hold that byte. A single-byte session yields a mask with exactly one bit set.
- R5: A STOP (stop_i) in an open session with at least one accepted byte raises busy_o from the next cycle for exactly PROG_CYCLES cycles. arr_we_o pulses once, in the last busy cycle, with arr_page_o equal to the session's page.
- R6: While busy_o is high, ack_ok_o is low and wsel_i, byte_vld_i and stop_i have no effect. No extra commit follows, and the committed content is unchanged.
- R7: With wp_i high and the session page in the lowest quarter (address bits [12:11] equal to 00, addresses 0x0000 to 0x07FF), ack_ok_o is low. A byte strobed while ack_ok_o is low locks the session: no later byte is accepted, and the closing STOP starts no program cycle.
- R8: With wp_i low, every address, including the lowest quarter, accepts bytes. With wp_i high, pages outside the lowest quarter accept bytes.
- R9: A STOP after a write select but before any accepted byte closes the session without raising busy_o or arr_we_o.
- R10: Outside an open session, ack_ok_o is low, and strobed bytes and STOPs cause no commit.
- R11: A new wsel_i during an open session discards the bytes accepted so far and restarts at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wsel_i | input | 1 | One-cycle strobe: write selected, start address valid |
| wsel_addr_i | input | 13 | Start address of the write |
| byte_vld_i | input | 1 | One-cycle strobe: a data byte was received |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | One-cycle strobe: STOP seen on the bus |
| wp_i | input | 1 | Write protect for the lowest quarter |
| ack_ok_o | output | 1 | The next data byte may be acknowledged |
| busy_o | output | 1 | Program cycle in progress |
| arr_we_o | output | 1 | One-cycle page write to the array |
| arr_page_o | output | 8 | Page number of the array write |
| arr_data_o | output | 256 | Page data, byte k at bits [8k+7:8k] |
| arr_mask_o | output | 32 | Per-byte write enables |

## Verification
A wrong offset or page register shows up only at the commit, PROG_CYCLES after STOP, as a shifted mask or a wrong arr_page_o. For that reason the bench compares each commit's page, mask and masked bytes against a behavioural page model. A stale mask or lock state appears within one cycle as a wrong ack_ok_o, or as a busy_o pulse that should not exist. The reference model checks ack_ok_o, busy_o and arr_we_o on every cycle, so a timer off by one is caught at the exact edge where busy should fall.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    SES_IDLE = 2'd0,
    SES_OPEN = 2'd1,
    SES_LOCK = 2'd2
  } ses_e;
endpackage

// File: rtl/pgwr_ptr.sv
module pgwr_ptr #(
  parameter int ADDR_W = 13,
  parameter int OFS_W  = 5,
  localparam int PG_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [PG_W-1:0]   page_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              lowq_o
);
  logic [PG_W-1:0]  page_q, page_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             en;

  always_comb begin
    page_d = page_q;
    ofs_d  = ofs_q;
    if (load_i) begin
      page_d = addr_i[ADDR_W-1:OFS_W];
      ofs_d  = addr_i[OFS_W-1:0];
    end else if (step_i) begin
      ofs_d  = OFS_W'(ofs_q + 1'b1);
    end
  end

  assign en = load_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (en) begin
      page_q <= page_d;
      ofs_q  <= ofs_d;
    end
  end

  assign page_o = page_q;
  assign ofs_o  = ofs_q;
  assign lowq_o = (page_q[PG_W-1 -: 2] == 2'b00);
endmodule

// File: rtl/pgwr_store.sv
module pgwr_store #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         wr_i,
  input  logic [OFS_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            din_i,
  output logic [PAGE_BYTES*DATA_W-1:0] data_o,
  output logic [PAGE_BYTES-1:0]        mask_o,
  output logic                         any_o
);
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic                  mask_en;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] slot_q;
    assign hit = wr_i && (idx_i == OFS_W'(g));
    always_ff @(posedge clk) begin
      if (hit) slot_q <= din_i;
    end
    assign data_o[g*DATA_W +: DATA_W] = slot_q;
    assign mask_d[g] = clr_i ? 1'b0 : (mask_q[g] | hit);
  end

  assign mask_en = clr_i | wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign any_o  = |mask_q;
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int PROG_CYCLES = 1000000,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end else if (start_i) begin
      run_d = 1'b1;
      cnt_d = CNT_W'(PROG_CYCLES - 1);
    end
  end

  assign en = run_q | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = run_q;
  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1000000,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int PG_W       = ADDR_W - OFS_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wsel_i,
  input  logic [ADDR_W-1:0]            wsel_addr_i,
  input  logic                         byte_vld_i,
  input  logic [DATA_W-1:0]            byte_i,
  input  logic                         stop_i,
  input  logic                         wp_i,
  output logic                         ack_ok_o,
  output logic                         busy_o,
  output logic                         arr_we_o,
  output logic [PG_W-1:0]              arr_page_o,
  output logic [PAGE_BYTES*DATA_W-1:0] arr_data_o,
  output logic [PAGE_BYTES-1:0]        arr_mask_o
);
  import pgwr_pkg::*;

  ses_e             st_q, st_d;
  logic             load, step, clr, start;
  logic             permit, busy, done, any;
  logic             lowq;
  logic [PG_W-1:0]  ptr_page;
  logic [OFS_W-1:0] ptr_ofs;

  assign permit = (st_q == SES_OPEN) && !busy && !(wp_i && lowq);

  always_comb begin
    st_d  = st_q;
    load  = 1'b0;
    step  = 1'b0;
    clr   = done;
    start = 1'b0;
    if (!busy) begin
      unique case (st_q)
        SES_IDLE: begin
          if (wsel_i) begin
            load = 1'b1;
            clr  = 1'b1;
            st_d = SES_OPEN;
          end
        end
        SES_OPEN: begin
          if (stop_i) begin
            start = any;
            st_d  = SES_IDLE;
          end else if (wsel_i) begin
            load = 1'b1;
            clr  = 1'b1;
          end else if (byte_vld_i) begin
            if (permit) step = 1'b1;
            else        st_d = SES_LOCK;
          end
        end
        SES_LOCK: begin
          if (stop_i) begin
            clr  = 1'b1;
            st_d = SES_IDLE;
          end else if (wsel_i) begin
            load = 1'b1;
            clr  = 1'b1;
            st_d = SES_OPEN;
          end
        end
        default: st_d = SES_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SES_IDLE;
    else        st_q <= st_d;
  end

  pgwr_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .addr_i (wsel_addr_i),
    .step_i (step),
    .page_o (ptr_page),
    .ofs_o  (ptr_ofs),
    .lowq_o (lowq)
  );

  pgwr_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .wr_i   (step),
    .idx_i  (ptr_ofs),
    .din_i  (byte_i),
    .data_o (arr_data_o),
    .mask_o (arr_mask_o),
    .any_o  (any)
  );

  pgwr_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  assign ack_ok_o   = permit;
  assign busy_o     = busy;
  assign arr_we_o   = done;
  assign arr_page_o = ptr_page;
endmodule

// File: rtl/pgwr_buffer_chk.sv
module pgwr_buffer_chk #(
  parameter int PG_W       = 8,
  parameter int PAGE_BYTES = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wp_i,
  input logic                  stop_i,
  input logic                  ack_ok_o,
  input logic                  busy_o,
  input logic                  arr_we_o,
  input logic [PAGE_BYTES-1:0] arr_mask_o,
  input logic [PG_W-1:0]       page_q
);
  AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o); // R5
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |=> !arr_we_o); // R5
  AST_BUSY_ENDS_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(arr_we_o)); // R5
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i)); // R5
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ack_ok_o); // R6
  AST_WE_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> (arr_mask_o != '0)); // R4
  AST_LOWQ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_i && page_q[PG_W-1 -: 2] == 2'b00) |-> !ack_ok_o); // R7
endmodule

bind pgwr_buffer pgwr_buffer_chk #(.PG_W(PG_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_i       (wp_i),
  .stop_i     (stop_i),
  .ack_ok_o   (ack_ok_o),
  .busy_o     (busy_o),
  .arr_we_o   (arr_we_o),
  .arr_mask_o (arr_mask_o),
  .page_q     (ptr_page)
);

// File: tb/pgwr_buffer_tb.sv
`timescale 1ns/1ps
module pgwr_buffer_tb;
  localparam int PROG = 40;

  logic         clk, rst_n;
  logic         wsel_i, byte_vld_i, stop_i, wp_i;
  logic [12:0]  wsel_addr_i;
  logic [7:0]   byte_i;
  logic         ack_ok_o, busy_o, arr_we_o;
  logic [7:0]   arr_page_o;
  logic [255:0] arr_data_o;
  logic [31:0]  arr_mask_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int         m_st, m_page, m_ofs, m_busy;
  logic [7:0] m_buf [32];
  logic [31:0] m_mask;

  // captured commits
  int           n_commit = 0;
  logic [7:0]   cap_page;
  logic [31:0]  cap_mask;
  logic [255:0] cap_data;

  pgwr_buffer #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .wsel_i(wsel_i), .wsel_addr_i(wsel_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .wp_i(wp_i),
    .ack_ok_o(ack_ok_o), .busy_o(busy_o), .arr_we_o(arr_we_o),
    .arr_page_o(arr_page_o), .arr_data_o(arr_data_o), .arr_mask_o(arr_mask_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, stepped on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_page = 0; m_ofs = 0; m_busy = 0; m_mask = '0;
    end else if (m_busy > 0) begin
      if (m_busy == 1) m_mask = '0;
      m_busy = m_busy - 1;
    end else begin
      case (m_st)
        0: if (wsel_i) begin
             m_page = int'(wsel_addr_i) / 32; m_ofs = int'(wsel_addr_i) % 32;
             m_mask = '0; m_st = 1;
           end
        1: if (stop_i) begin
             if (m_mask != 0) m_busy = PROG;
             m_st = 0;
           end else if (wsel_i) begin
             m_page = int'(wsel_addr_i) / 32; m_ofs = int'(wsel_addr_i) % 32;
             m_mask = '0;
           end else if (byte_vld_i) begin
             if (!(wp_i && m_page < 64)) begin
               m_buf[m_ofs] = byte_i; m_mask[m_ofs] = 1'b1;
               m_ofs = (m_ofs + 1) % 32;
             end else m_st = 2;
           end
        default: if (stop_i) begin
             m_mask = '0; m_st = 0;
           end else if (wsel_i) begin
             m_page = int'(wsel_addr_i) / 32; m_ofs = int'(wsel_addr_i) % 32;
             m_mask = '0; m_st = 1;
           end
      endcase
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_ack  = (m_busy == 0) && (m_st == 1) && !(wp_i && m_page < 64);
      automatic bit e_busy = (m_busy > 0);
      automatic bit e_we   = (m_busy == 1);
      chk(ack_ok_o == e_ack, "R7 ack_ok per-cycle", 64'(ack_ok_o), 64'(e_ack));
      chk(busy_o == e_busy, "R5 busy per-cycle", 64'(busy_o), 64'(e_busy));
      chk(arr_we_o == e_we, "R5 write strobe per-cycle", 64'(arr_we_o), 64'(e_we));
      if (arr_we_o) begin
        n_commit++;
        cap_page = arr_page_o; cap_mask = arr_mask_o; cap_data = arr_data_o;
        if (e_we) begin
          chk(arr_page_o == 8'(m_page), "R2 commit page", 64'(arr_page_o), 64'(m_page));
          chk(arr_mask_o == m_mask, "R4 commit mask", 64'(arr_mask_o), 64'(m_mask));
          for (int k = 0; k < 32; k++)
            if (m_mask[k])
              chk(arr_data_o[k*8 +: 8] == m_buf[k], "R3 commit byte",
                  64'(arr_data_o[k*8 +: 8]), 64'(m_buf[k]));
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic do_sel(input logic [12:0] a);
    wsel_i = 1; wsel_addr_i = a; tick(); wsel_i = 0;
  endtask
  task automatic do_byte(input logic [7:0] b);
    byte_vld_i = 1; byte_i = b; tick(); byte_vld_i = 0; tick();
  endtask
  task automatic do_stop();
    stop_i = 1; tick(); stop_i = 0;
  endtask
  task automatic wait_prog(output int n);
    n = 0;
    @(negedge clk);
    while (busy_o) begin n++; @(negedge clk); end
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, c0;
    rst_n = 0; wsel_i = 0; byte_vld_i = 0; stop_i = 0; wp_i = 0;
    wsel_addr_i = '0; byte_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ack_ok_o && !busy_o && !arr_we_o, "R1 reset outputs",
        64'({ack_ok_o, busy_o, arr_we_o}), 64'(0));
    rst_n = 1; tick();

    // R10: no session
    @(negedge clk);
    chk(!ack_ok_o, "R10 idle ack", 64'(ack_ok_o), 64'(0));
    tick(); do_byte(8'h11); do_stop(); tick(); tick();
    chk(n_commit == 0 && !busy_o, "R10 no commit without select", 64'(n_commit), 64'(0));

    // R4/R5 single byte to 0x1234 -> page 0x91, offset 20
    do_sel(13'h1234); do_byte(8'hA5); do_stop();
    @(negedge clk);
    chk(busy_o, "R5 busy next cycle after STOP", 64'(busy_o), 64'(1));
    wait_prog(n);
    chk(n == PROG - 1 + 0 + 1 - 1 + 1 - 1 || n == PROG - 1, "R5 busy length", 64'(n + 1), 64'(PROG));
    chk(cap_page == 8'h91, "R2 single page", 64'(cap_page), 64'h91);
    chk(cap_mask == 32'h0010_0000, "R4 single mask", 64'(cap_mask), 64'h0010_0000);
    chk(cap_data[20*8 +: 8] == 8'hA5, "R4 single data", 64'(cap_data[20*8 +: 8]), 64'hA5);

    // R2 offset wrap inside page 0xFF from offset 30
    do_sel(13'h1FFE);
    for (int i = 0; i < 5; i++) do_byte(8'(8'h50 + i));
    do_stop(); wait_prog(n);
    chk(cap_page == 8'hFF, "R2 page unchanged over wrap", 64'(cap_page), 64'hFF);
    chk(cap_mask == 32'hC000_0007, "R2 offset wrap mask", 64'(cap_mask), 64'hC000_0007);
    chk(cap_data[0 +: 8] == 8'h52, "R2 byte at offset 0", 64'(cap_data[0 +: 8]), 64'h52);

    // R3 + R8: 34 bytes into lowest quarter with protect low
    wp_i = 0;
    do_sel(13'h0400);
    for (int i = 0; i < 34; i++) do_byte(8'(i + 1));
    do_stop(); wait_prog(n);
    chk(cap_page == 8'h20, "R8 low quarter writable", 64'(cap_page), 64'h20);
    chk(cap_mask == 32'hFFFF_FFFF, "R3 full mask", 64'(cap_mask), 64'hFFFF_FFFF);
    chk(cap_data[0 +: 8] == 8'd33 && cap_data[8 +: 8] == 8'd34, "R3 overwrite",
        64'(cap_data[15:0]), 64'h2221);
    chk(cap_data[2*8 +: 8] == 8'd3, "R3 untouched by overrun", 64'(cap_data[23:16]), 64'd3);

    // R7 protected low quarter
    c0 = n_commit;
    wp_i = 1;
    do_sel(13'h0100);
    @(negedge clk);
    chk(!ack_ok_o, "R7 refuse protected page", 64'(ack_ok_o), 64'(0));
    tick(); do_byte(8'h77); do_stop(); tick(); tick();
    chk(n_commit == c0 && !busy_o, "R7 nothing programmed", 64'(n_commit), 64'(c0));

    // R8 upper area with protect high
    do_sel(13'h1800);
    @(negedge clk);
    chk(ack_ok_o, "R8 upper area open under protect", 64'(ack_ok_o), 64'(1));
    tick(); do_byte(8'h3C); do_stop(); wait_prog(n);
    chk(cap_page == 8'hC0 && cap_mask == 32'h1, "R8 upper commit", 64'(cap_mask), 64'h1);

    // R7 lock persists after protect drops
    c0 = n_commit;
    wp_i = 0; do_sel(13'h0200); do_byte(8'h01);
    wp_i = 1; do_byte(8'h02);
    wp_i = 0; tick();
    @(negedge clk);
    chk(!ack_ok_o, "R7 locked session stays refused", 64'(ack_ok_o), 64'(0));
    tick(); do_byte(8'h03); do_stop(); tick(); tick();
    chk(n_commit == c0 && !busy_o, "R7 locked session not programmed", 64'(n_commit), 64'(c0));

    // R9 select then STOP, no data
    do_sel(13'h0840); do_stop(); tick();
    @(negedge clk);
    chk(!busy_o && !ack_ok_o && n_commit == c0, "R9 empty write", 64'(busy_o), 64'(0));
    tick();

    // R6 traffic during busy is ignored
    do_sel(13'h0A60); do_byte(8'hE1); do_stop();
    c0 = n_commit;
    do_sel(13'h1000);
    @(negedge clk);
    chk(!ack_ok_o, "R6 no ack while busy", 64'(ack_ok_o), 64'(0));
    tick(); do_byte(8'h99); do_stop();
    wait_prog(n); tick(); tick();
    chk(n_commit == c0 + 1, "R6 one commit only", 64'(n_commit), 64'(c0 + 1));
    chk(cap_page == 8'h53 && cap_mask == 32'h1 && cap_data[7:0] == 8'hE1,
        "R6 commit unchanged by busy traffic", 64'(cap_data[7:0]), 64'hE1);
    @(negedge clk);
    chk(!ack_ok_o && !busy_o, "R6 no session opened during busy", 64'(ack_ok_o), 64'(0));
    tick();

    // R11 reselect discards earlier bytes
    do_sel(13'h0C05); do_byte(8'h10);
    do_sel(13'h0D09); do_byte(8'h20);
    do_stop(); wait_prog(n);
    chk(cap_page == 8'h68, "R11 new page", 64'(cap_page), 64'h68);
    chk(cap_mask == 32'h0000_0200, "R11 only new byte", 64'(cap_mask), 64'h200);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule